// File: doc/BRIEF.md
# I2C Bus Condition and Acknowledge Flag Monitor

This block watches the clock and data lines of an I2C bus after they have passed through a synchronizer. It drives no line itself. From the line activity it keeps three status flags: a start flag, a stop flag and an acknowledge flag. Each flag sets and clears on its own rules, which depend on bus conditions, on where the current clock sits inside the nine-clock byte, on a release command and on the interface enable. A byte-clock counter tracks that position. It is cleared by a start condition, and it counts bits 1 to 9, where clock 9 carries the acknowledge.

A small configuration/flag register sits alongside the status flags. It holds two writable bits, a reservation enable and an initial-busy select, which accept writes only while the interface is disabled. It also holds two read-only bits: bus busy and a start-failure indicator. A simple one-cycle write strobe and a combinational read port give access to both registers. The enable input turns monitoring on and off, and a one-cycle release input makes the monitor leave the current transfer.

Top module: `i2c_flag_monitor`

## Requirements
- R1: A start condition (SDA falling while SCL is held high) sets the start flag and the busy bit, and resets the byte-clock position to 0.
- R2: The start flag clears on a stop condition, on the SCL rising edge that opens the byte after the address byte (position 9 wrapping to 1), and on a release pulse.
- R3: A stop condition (SDA rising while SCL is held high) sets the stop flag. The flag stays set across release pulses and clears only on the first SCL rising edge after a new start condition (position 0 to 1), or when the interface is disabled.
- R4: The acknowledge flag sets on the SCL rising edge that takes the position from 8 to 9 if SDA is low at that edge. With SDA high at that edge (no acknowledge) it stays clear.
- R5: The acknowledge flag clears on the next byte's first SCL rising edge (position 9 to 1), on a stop condition and on a release pulse.
- R6: The byte-clock position `bit_pos` counts SCL rising edges 1 through 9 and wraps from 9 to 1. It never exceeds 9.
- R7: While `enable` is low, all three status flags, busy, start failure and the position are held at 0. A 1-to-0 change of `enable` clears them on the next clock.
- R8: The flag register resets to 0x00. Its writable bits are bit 0 (reservation enable) and bit 1 (initial-busy select). A write with `reg_sel`=1 changes them only while `enable` is 0, and writes to bits 6 and 7 have no effect.
- R9: The busy bit clears on a stop condition. When `enable` rises, busy takes the value of the initial-busy select bit.
- R10: The start-failure bit sets when a start condition arrives with the position between 2 and 8 (inside a byte). It clears on a stop condition, on a release pulse and on disable.
- R11: With `reg_sel`=0, `reg_rdata` shows stop in bit 0, start in bit 1 and acknowledge in bit 2. With `reg_sel`=1 it shows reservation enable in bit 0, initial-busy select in bit 1, start failure in bit 6 and busy in bit 7. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| enable | input | 1 | Interface enable |
| release_req | input | 1 | One-cycle command to leave the current transfer |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 status, 1 flag/config |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data of the selected register |
| flag_start | output | 1 | Start condition flag |
| flag_stop | output | 1 | Stop condition flag |
| flag_ack | output | 1 | Acknowledge flag |
| bus_busy | output | 1 | Bus busy bit |
| start_fail | output | 1 | Start failure bit |
| bit_pos | output | CNT_W | Byte-clock position, 0 to BITS_PER_BYTE+1 |

## Verification
The bench uses the default parameters: a two-stage synchronizer, eight data bits per byte and an eight-bit register width. With these values the full nine-clock byte is exercised, including the acknowledge position and the 9-to-1 wrap. The short synchronizer latency lets each line step settle within six clocks, so every flag can be compared against a bench model after each individual bus step. A repeated start, a start placed inside a byte, and a disable in the middle of a transfer are all reachable within a few hundred clocks.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

    // status register bit positions
    localparam int unsigned ST_STOP_BIT  = 0;
    localparam int unsigned ST_START_BIT = 1;
    localparam int unsigned ST_ACK_BIT   = 2;

    // flag/config register bit positions
    localparam int unsigned CF_RSV_BIT   = 0;
    localparam int unsigned CF_BINIT_BIT = 1;
    localparam int unsigned CF_SFAIL_BIT = 6;
    localparam int unsigned CF_BUSY_BIT  = 7;

    typedef struct packed {
        logic start_ev;
        logic stop_ev;
        logic scl_rise;
        logic sda_lvl;
    } bus_ev_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic ack;
        logic sfail;
        logic busy;
    } flag_state_t;

    typedef struct packed {
        logic rsv_en;
        logic busy_init;
    } cfg_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_in,
    input  logic                 sda_in,
    output i2c_mon_pkg::bus_ev_t ev
);
    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_prev;
        logic              sda_prev;
    } sync_state_t;

    sync_state_t st_d, st_q;
    logic scl_now, sda_now;

    always_comb begin
        st_d          = st_q;
        st_d.scl_sh   = {st_q.scl_sh[STAGES-2:0], scl_in};
        st_d.sda_sh   = {st_q.sda_sh[STAGES-2:0], sda_in};
        st_d.scl_prev = st_q.scl_sh[STAGES-1];
        st_d.sda_prev = st_q.sda_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign scl_now = st_q.scl_sh[STAGES-1];
    assign sda_now = st_q.sda_sh[STAGES-1];

    always_comb begin
        ev.scl_rise = scl_now & ~st_q.scl_prev;
        ev.start_ev = scl_now & st_q.scl_prev & st_q.sda_prev & ~sda_now;
        ev.stop_ev  = scl_now & st_q.scl_prev & ~st_q.sda_prev & sda_now;
        ev.sda_lvl  = sda_now;
    end
endmodule

// File: rtl/i2c_bit_counter.sv
module i2c_bit_counter #(
    parameter int unsigned CNT_W = 4,
    parameter int unsigned LAST  = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  i2c_mon_pkg::bus_ev_t ev,
    output logic [CNT_W-1:0]     cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!enable)
            cnt_d = '0;
        else if (ev.start_ev)
            cnt_d = '0;
        else if (ev.scl_rise)
            cnt_d = (cnt_q == CNT_W'(LAST)) ? CNT_W'(1) : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags #(
    parameter int unsigned CNT_W = 4,
    parameter int unsigned LAST  = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     en_rise,
    input  logic                     release_req,
    input  logic                     busy_init,
    input  i2c_mon_pkg::bus_ev_t     ev,
    input  logic [CNT_W-1:0]         cnt,
    output i2c_mon_pkg::flag_state_t flags
);
    import i2c_mon_pkg::*;

    localparam logic [CNT_W-1:0] POS_ACK  = CNT_W'(LAST);
    localparam logic [CNT_W-1:0] POS_LAST_DATA = CNT_W'(LAST - 1);
    localparam logic [CNT_W-1:0] POS_MID_LO    = CNT_W'(2);

    flag_state_t fl_d, fl_q;
    logic        mid_byte;

    assign mid_byte = (cnt >= POS_MID_LO) && (cnt <= POS_LAST_DATA);

    always_comb begin
        fl_d = fl_q;
        if (!enable) begin
            fl_d = '0;
        end else begin
            if (en_rise)
                fl_d.busy = busy_init;
            if (ev.scl_rise) begin
                // first clock of an address byte ends the stop indication
                if (cnt == '0)
                    fl_d.stop = 1'b0;
                // first clock of any following byte
                if (cnt == POS_ACK) begin
                    fl_d.ack   = 1'b0;
                    fl_d.start = 1'b0;
                end
                // acknowledge clock sampled with data driven low
                if (cnt == POS_LAST_DATA && !ev.sda_lvl)
                    fl_d.ack = 1'b1;
            end
            if (ev.start_ev) begin
                fl_d.start = 1'b1;
                fl_d.busy  = 1'b1;
                if (mid_byte)
                    fl_d.sfail = 1'b1;
            end
            if (ev.stop_ev) begin
                fl_d.stop  = 1'b1;
                fl_d.start = 1'b0;
                fl_d.ack   = 1'b0;
                fl_d.busy  = 1'b0;
                fl_d.sfail = 1'b0;
            end
            if (release_req) begin
                fl_d.start = 1'b0;
                fl_d.ack   = 1'b0;
                fl_d.sfail = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flags = fl_q;
endmodule

// File: rtl/i2c_cfg_reg.sv
module i2c_cfg_reg (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_en,
    input  logic              wr_rsv,
    input  logic              wr_binit,
    output i2c_mon_pkg::cfg_t cfg
);
    import i2c_mon_pkg::*;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && !enable) begin
            cfg_d.rsv_en    = wr_rsv;
            cfg_d.busy_init = wr_binit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/i2c_flag_monitor.sv
module i2c_flag_monitor #(
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned BITS_PER_BYTE = 8,
    parameter int unsigned REG_W         = 8,
    localparam int unsigned ACK_POS      = BITS_PER_BYTE + 1,
    localparam int unsigned CNT_W        = $clog2(BITS_PER_BYTE + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             enable,
    input  logic             release_req,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             flag_start,
    output logic             flag_stop,
    output logic             flag_ack,
    output logic             bus_busy,
    output logic             start_fail,
    output logic [CNT_W-1:0] bit_pos
);
    import i2c_mon_pkg::*;

    bus_ev_t     bus_ev;
    flag_state_t flags;
    cfg_t        cfg;
    logic [CNT_W-1:0] cnt;
    logic        en_d, en_q;
    logic        en_rise;
    logic        start_ev, stop_ev;
    logic [1:0]  cfg_bits;
    logic        wdata_unused;

    always_comb en_d = enable;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    assign en_rise = enable & ~en_q;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (bus_ev)
    );

    i2c_bit_counter #(.CNT_W(CNT_W), .LAST(ACK_POS)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .ev     (bus_ev),
        .cnt    (cnt)
    );

    i2c_status_flags #(.CNT_W(CNT_W), .LAST(ACK_POS)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .en_rise     (en_rise),
        .release_req (release_req),
        .busy_init   (cfg.busy_init),
        .ev          (bus_ev),
        .cnt         (cnt),
        .flags       (flags)
    );

    i2c_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .wr_en    (reg_wr & reg_sel),
        .wr_rsv   (reg_wdata[CF_RSV_BIT]),
        .wr_binit (reg_wdata[CF_BINIT_BIT]),
        .cfg      (cfg)
    );

    // read mux: status when reg_sel is 0, flag/config when 1
    always_comb begin
        reg_rdata = '0;
        if (!reg_sel) begin
            reg_rdata[ST_STOP_BIT]  = flags.stop;
            reg_rdata[ST_START_BIT] = flags.start;
            reg_rdata[ST_ACK_BIT]   = flags.ack;
        end else begin
            reg_rdata[CF_RSV_BIT]   = cfg.rsv_en;
            reg_rdata[CF_BINIT_BIT] = cfg.busy_init;
            reg_rdata[CF_SFAIL_BIT] = flags.sfail;
            reg_rdata[CF_BUSY_BIT]  = flags.busy;
        end
    end

    assign flag_start   = flags.start;
    assign flag_stop    = flags.stop;
    assign flag_ack     = flags.ack;
    assign bus_busy     = flags.busy;
    assign start_fail   = flags.sfail;
    assign bit_pos      = cnt;
    assign start_ev     = bus_ev.start_ev;
    assign stop_ev      = bus_ev.stop_ev;
    assign cfg_bits     = {cfg.busy_init, cfg.rsv_en};
    assign wdata_unused = ^reg_wdata;
endmodule

// File: rtl/i2c_mon_checker.sv
module i2c_mon_checker #(
    parameter int unsigned CNT_W = 4,
    parameter int unsigned LAST  = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             release_req,
    input logic             start_ev,
    input logic             stop_ev,
    input logic             flag_start,
    input logic             flag_stop,
    input logic             flag_ack,
    input logic             bus_busy,
    input logic [CNT_W-1:0] bit_pos,
    input logic [1:0]       cfg_bits
);
    assert_start_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && start_ev && !release_req) |=> (flag_start && bus_busy && bit_pos == '0));

    assert_stop_clears_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && stop_ev) |=> !flag_start);

    assert_stop_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && stop_ev) |=> (flag_stop && !bus_busy));

    assert_ack_at_ninth_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_ack) |-> (bit_pos == CNT_W'(LAST)));

    assert_pos_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_pos <= CNT_W'(LAST));

    assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!flag_start && !flag_stop && !flag_ack && !bus_busy));

    assert_cfg_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> $stable(cfg_bits));
endmodule

bind i2c_flag_monitor i2c_mon_checker #(.CNT_W(CNT_W), .LAST(ACK_POS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .release_req (release_req),
    .start_ev    (start_ev),
    .stop_ev     (stop_ev),
    .flag_start  (flag_start),
    .flag_stop   (flag_stop),
    .flag_ack    (flag_ack),
    .bus_busy    (bus_busy),
    .bit_pos     (bit_pos),
    .cfg_bits    (cfg_bits)
);

// File: tb/i2c_flag_monitor_tb_top.sv
`timescale 1ns/1ps
module i2c_flag_monitor_tb_top;
    localparam int HALF  = 6;
    localparam int LIMIT = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda = 1'b1;
    logic       enable = 1'b0, release_req = 1'b0;
    logic       reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       flag_start, flag_stop, flag_ack, bus_busy, start_fail;
    logic [3:0] bit_pos;

    int n_vec = 0, n_err = 0, cycles = 0;
    bit done = 0;

    // bench model
    bit m_en = 0, m_start = 0, m_stop = 0, m_ack = 0, m_busy = 0, m_sfail = 0;
    bit m_rsv = 0, m_binit = 0;
    int m_cnt = 0;

    always #2.5 clk = ~clk;

    i2c_flag_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
        .enable(enable), .release_req(release_req),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .flag_start(flag_start), .flag_stop(flag_stop),
        .flag_ack(flag_ack), .bus_busy(bus_busy), .start_fail(start_fail),
        .bit_pos(bit_pos)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == LIMIT && !done) begin
            n_err++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_all();
        logic [7:0] exp_st, exp_cf;
        exp_st = {5'b0, m_ack, m_start, m_stop};
        exp_cf = {m_busy, m_sfail, 4'b0, m_binit, m_rsv};
        chk("R1 R2 start flag", flag_start, m_start);
        chk("R3 stop flag", flag_stop, m_stop);
        chk("R4 R5 ack flag", flag_ack, m_ack);
        chk("R6 bit_pos", bit_pos, m_cnt);
        chk("R9 busy", bus_busy, m_busy);
        chk("R10 start_fail", start_fail, m_sfail);
        reg_sel = 1'b0; #0.5;
        chk("R11 status read", reg_rdata, exp_st);
        reg_sel = 1'b1; #0.5;
        chk("R11 flag read", reg_rdata, exp_cf);
    endtask

    // one line step, applying the model's event rules
    task automatic drive(input logic nscl, input logic nsda);
        @(negedge clk);
        if (m_en) begin
            if (!scl && nscl) begin
                if (m_cnt == 0) m_stop = 0;
                if (m_cnt == 9) begin m_ack = 0; m_start = 0; end
                if (m_cnt == 8 && !nsda) m_ack = 1;
                m_cnt = (m_cnt == 9) ? 1 : m_cnt + 1;
            end
            if (scl && nscl && sda && !nsda) begin
                if (m_cnt >= 2 && m_cnt <= 8) m_sfail = 1;
                m_start = 1; m_busy = 1; m_cnt = 0;
            end
            if (scl && nscl && !sda && nsda) begin
                m_stop = 1; m_start = 0; m_ack = 0; m_busy = 0; m_sfail = 0;
            end
        end
        scl = nscl; sda = nsda;
        repeat (HALF) @(negedge clk);
        check_all();
    endtask

    task automatic bus_start();
        if (!scl) begin
            drive(1'b0, 1'b1); drive(1'b1, 1'b1);
        end else if (!sda) begin
            drive(1'b0, 1'b0); drive(1'b0, 1'b1); drive(1'b1, 1'b1);
        end
        drive(1'b1, 1'b0);
        drive(1'b0, 1'b0);
    endtask

    task automatic bus_bit(input logic b);
        drive(1'b0, b); drive(1'b1, b); drive(1'b0, b);
    endtask

    task automatic bus_byte(input logic [7:0] v, input logic ackbit);
        for (int i = 7; i >= 0; i--) bus_bit(v[i]);
        bus_bit(ackbit);
    endtask

    task automatic bus_stop();
        drive(1'b0, 1'b0); drive(1'b1, 1'b0); drive(1'b1, 1'b1);
    endtask

    task automatic set_enable(input logic v);
        @(negedge clk);
        enable = v;
        if (m_en && !v) begin
            m_start = 0; m_stop = 0; m_ack = 0; m_busy = 0; m_sfail = 0; m_cnt = 0;
        end
        if (!m_en && v) m_busy = m_binit;
        m_en = v;
        repeat (2) @(negedge clk);
        check_all();
    endtask

    task automatic release_pulse();
        @(negedge clk);
        release_req = 1'b1;
        if (m_en) begin m_start = 0; m_ack = 0; m_sfail = 0; end
        @(negedge clk);
        release_req = 1'b0;
        @(negedge clk);
        check_all();
    endtask

    task automatic reg_write(input logic [7:0] v);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = v;
        if (!m_en) begin m_rsv = v[0]; m_binit = v[1]; end
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
        check_all();
    endtask

    // scenarios
    task automatic test_reset();
        check_all();
        chk("R8 flag reg reset 0x00", reg_rdata, 0);
    endtask

    task automatic test_cfg();
        reg_write(8'hC3);             // R8: ro bits ignored, rw bits taken
        set_enable(1'b1);             // R9: busy loads initial-busy select
        chk("R9 busy loaded from select", bus_busy, 1);
        reg_write(8'h00);             // R8: ignored while enabled
        chk("R8 write ignored when enabled", reg_rdata, 8'h83);
        set_enable(1'b0);
        reg_write(8'h01);
        set_enable(1'b1);
        chk("R9 busy loaded 0", bus_busy, 0);
    endtask

    task automatic test_addr_ack();
        bus_start();
        chk("R1 start after start cond", flag_start, 1);
        bus_byte(8'hA4, 1'b0);
        chk("R4 ack set on ninth clock", flag_ack, 1);
        chk("R6 position at ninth", bit_pos, 9);
    endtask

    task automatic test_data_nack();
        bus_byte(8'h5B, 1'b1);
        chk("R2 start cleared by next byte", flag_start, 0);
        chk("R4 no ack on nack", flag_ack, 0);
    endtask

    task automatic test_rstart_release();
        bus_start();
        bus_byte(8'h3C, 1'b0);
        release_pulse();
        chk("R5 ack cleared by release", flag_ack, 0);
        bus_stop();
        chk("R3 stop flag set", flag_stop, 1);
        release_pulse();
        chk("R3 stop survives release", flag_stop, 1);
        bus_start();
        drive(1'b0, 1'b1); drive(1'b1, 1'b1);
        chk("R3 stop cleared on first clock after start", flag_stop, 0);
        drive(1'b0, 1'b1);
    endtask

    task automatic test_sfail();
        bus_bit(1'b1); bus_bit(1'b0);
        bus_start();
        chk("R10 start inside byte flags failure", start_fail, 1);
        bus_stop();
        chk("R10 failure cleared by stop", start_fail, 0);
    endtask

    task automatic test_disable();
        bus_start();
        bus_byte(8'h12, 1'b0);
        set_enable(1'b0);
        chk("R7 flags cleared on disable", {flag_start, flag_ack, bus_busy}, 0);
        set_enable(1'b1);
        drive(1'b0, 1'b1); drive(1'b1, 1'b1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset();
        test_cfg();
        test_addr_ack();
        test_data_nack();
        test_rstart_release();
        test_sfail();
        test_disable();
        done = 1;
        summary();
        $finish;
    end
endmodule